// File: doc/BRIEF.md
# PLL Lock Detector with Digital Filter

This block decides whether a phase-locked loop has settled. It runs on a fast sampling clock and watches two divided signals: the divided reference and the divided feedback. In each comparison cycle it counts the sampling ticks between the rising edge that arrives first and the rising edge that arrives second. That count is the phase error. A filter state machine turns a run of small errors into a lock indication. A single large error clears the indication. An error that falls between the two thresholds leaves the indication unchanged but restarts the run. This gap between the thresholds gives the detector hysteresis.

A second flag gives a simpler, analog-style view of lock. The flag is high after a comparison cycle in which the charge pump never drove, and low after a cycle in which it did. A 2-bit selector routes one of four signals to a single status pin: the filtered lock, the analog-style flag, the divided reference or the divided feedback. A power-down input forces both lock indications low and clears the filter state. The two thresholds, the run length, the timeout and the tick resolution are all parameters. The tick resolution follows from the chosen sampling clock.

The measurement machine has three states:
- `MS_IDLE`: waiting for a first edge.
- `MS_REF_LEAD`: the reference edge came first.
- `MS_FB_LEAD`: the feedback edge came first.

It has these transitions:
- From `MS_IDLE`, a lone first edge enters one of the lead states. Two simultaneous edges report an error of 0.
- From a lead state, the other edge completes the measurement and returns to `MS_IDLE`.
- From a lead state, a second edge of the same kind reports a large error and restarts the wait.
- From a lead state, reaching the timeout reports a large error and returns to `MS_IDLE`.

The filter machine has two states, `FS_UNLOCKED` and `FS_LOCKED`:
- The run of small errors reaching its target moves `FS_UNLOCKED` to `FS_LOCKED`.
- A large error moves `FS_LOCKED` to `FS_UNLOCKED`.
- Power-down forces `FS_UNLOCKED` from either state.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, `locked` is 0, and `status_out` is 0 while `mode_sel` is 0.
- R2: The phase error is the number of sampling ticks between the first and the second rising edge of `ref_div` and `fb_div`, whichever signal leads. Rising edges seen at the same tick give an error of 0.
- R3: `locked` rises once GOOD_RUN consecutive comparison cycles end with an error below LOW_TICKS. It is high from the second clock edge after the edge that completes the last of those cycles.
- R4: A comparison cycle whose error exceeds HIGH_TICKS makes `locked` low by the second clock edge after it completes.
- R5: An error from LOW_TICKS to HIGH_TICKS inclusive leaves `locked` unchanged and restarts the count of consecutive small errors.
- R6: In analog-style mode (`mode_sel` = 1), at the end of each comparison cycle `status_out` becomes 1 if `cp_active` stayed low through that cycle, and 0 otherwise.
- R7: `mode_sel` selects the source of `status_out`: 0 gives the filtered lock, 1 the analog-style flag, 2 `ref_div` and 3 `fb_div`.
- R8: A comparison cycle counts as a large error in two cases: when TIMEOUT_TICKS ticks pass after a first edge with no edge on the other signal, or when the leading signal rises again before the other signal does.
- R9: While `pwr_dn` is high, `locked` and the analog-style flag read 0. Leaving power-down starts from the unlocked state with an empty run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one period is one tick of error |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div | input | 1 | Divided reference signal |
| fb_div | input | 1 | Divided feedback signal |
| pwr_dn | input | 1 | Power-down; forces lock indications low |
| cp_active | input | 1 | High while the charge pump is driving |
| mode_sel | input | 2 | Status pin source: 0 filtered, 1 analog-style, 2 reference, 3 feedback |
| locked | output | 1 | Filtered lock indication |
| status_out | output | 1 | Multiplexed status pin |

## Verification
The bench builds the block with LOW_TICKS = 6, HIGH_TICKS = 12, GOOD_RUN = 5 and TIMEOUT_TICKS = 30. With these values, gaps of 5, 6, 12 and 13 ticks sit exactly on both sides of both thresholds. The short timeout lets a lone edge expire within a few dozen cycles. Runs of four and five small errors, with a mid-band error placed in between, show both the run length and the restart of the run.

// File: rtl/ld_pkg.sv
package ld_pkg;

    typedef enum logic [1:0] {
        MS_IDLE     = 2'd0,
        MS_REF_LEAD = 2'd1,
        MS_FB_LEAD  = 2'd2
    } meas_state_t;

    typedef enum logic {
        FS_UNLOCKED = 1'b0,
        FS_LOCKED   = 1'b1
    } filt_state_t;

    typedef enum logic [1:0] {
        OSEL_FILTERED = 2'd0,
        OSEL_ANALOG   = 2'd1,
        OSEL_REF      = 2'd2,
        OSEL_FB       = 2'd3
    } osel_t;

    typedef enum logic [1:0] {
        ERR_SMALL = 2'd0,
        ERR_MID   = 2'd1,
        ERR_LARGE = 2'd2
    } err_class_t;

endpackage

// File: rtl/ld_edge_meas.sv
module ld_edge_meas
    import ld_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 64,
    parameter int ERR_W         = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_div,
    input  logic             fb_div,
    output logic             meas_valid,
    output logic [ERR_W-1:0] meas_err,
    output logic             meas_timeout
);

    localparam logic [ERR_W-1:0] TMO_L = ERR_W'(TIMEOUT_TICKS);
    localparam logic [ERR_W-1:0] ONE_L = ERR_W'(1);

    meas_state_t      state_q, state_n;
    logic [ERR_W-1:0] cnt_q, cnt_n;
    logic             ref_q, fb_q;
    logic             ref_rise, fb_rise;
    logic             v_n, to_n;
    logic [ERR_W-1:0] e_n;

    assign ref_rise = ref_div & ~ref_q;
    assign fb_rise  = fb_div  & ~fb_q;

    // state register and captured results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= MS_IDLE;
            cnt_q        <= '0;
            ref_q        <= 1'b0;
            fb_q         <= 1'b0;
            meas_valid   <= 1'b0;
            meas_err     <= '0;
            meas_timeout <= 1'b0;
        end else begin
            state_q      <= state_n;
            cnt_q        <= cnt_n;
            ref_q        <= ref_div;
            fb_q         <= fb_div;
            meas_valid   <= v_n;
            meas_err     <= e_n;
            meas_timeout <= to_n;
        end
    end

    // transitions and per-cycle result
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        v_n     = 1'b0;
        e_n     = '0;
        to_n    = 1'b0;
        unique case (state_q)
            MS_IDLE: begin
                if (ref_rise && fb_rise) begin
                    v_n = 1'b1;
                end else if (ref_rise) begin
                    state_n = MS_REF_LEAD;
                    cnt_n   = ONE_L;
                end else if (fb_rise) begin
                    state_n = MS_FB_LEAD;
                    cnt_n   = ONE_L;
                end
            end
            MS_REF_LEAD: begin
                if (fb_rise) begin
                    v_n     = 1'b1;
                    e_n     = cnt_q;
                    state_n = MS_IDLE;
                end else if (ref_rise) begin
                    v_n   = 1'b1;
                    to_n  = 1'b1;
                    cnt_n = ONE_L;
                end else if (cnt_q == TMO_L) begin
                    v_n     = 1'b1;
                    to_n    = 1'b1;
                    state_n = MS_IDLE;
                end else begin
                    cnt_n = cnt_q + ONE_L;
                end
            end
            MS_FB_LEAD: begin
                if (ref_rise) begin
                    v_n     = 1'b1;
                    e_n     = cnt_q;
                    state_n = MS_IDLE;
                end else if (fb_rise) begin
                    v_n   = 1'b1;
                    to_n  = 1'b1;
                    cnt_n = ONE_L;
                end else if (cnt_q == TMO_L) begin
                    v_n     = 1'b1;
                    to_n    = 1'b1;
                    state_n = MS_IDLE;
                end else begin
                    cnt_n = cnt_q + ONE_L;
                end
            end
            default: begin
                state_n = MS_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

endmodule

// File: rtl/ld_lock_filter.sv
module ld_lock_filter
    import ld_pkg::*;
#(
    parameter int LOW_TICKS  = 6,
    parameter int HIGH_TICKS = 12,
    parameter int GOOD_RUN   = 5,
    parameter int ERR_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             meas_valid,
    input  logic [ERR_W-1:0] meas_err,
    input  logic             meas_timeout,
    output logic             lock_q
);

    localparam int               RUN_W  = $clog2(GOOD_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_L  = RUN_W'(GOOD_RUN);
    localparam logic [RUN_W-1:0] LAST_L = RUN_W'(GOOD_RUN - 1);
    localparam logic [ERR_W-1:0] LOW_L  = ERR_W'(LOW_TICKS);
    localparam logic [ERR_W-1:0] HIGH_L = ERR_W'(HIGH_TICKS);

    filt_state_t      state_q, state_n;
    logic [RUN_W-1:0] run_q, run_n;
    err_class_t       cls;

    always_comb begin
        if (meas_timeout || meas_err > HIGH_L) cls = ERR_LARGE;
        else if (meas_err < LOW_L)             cls = ERR_SMALL;
        else                                   cls = ERR_MID;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_UNLOCKED;
            run_q   <= '0;
        end else begin
            state_q <= state_n;
            run_q   <= run_n;
        end
    end

    always_comb begin
        state_n = state_q;
        run_n   = run_q;
        if (pwr_dn) begin
            state_n = FS_UNLOCKED;
            run_n   = '0;
        end else if (meas_valid) begin
            // saturating run of small errors
            if (cls == ERR_SMALL) run_n = (run_q >= LAST_L) ? RUN_L : run_q + 1'b1;
            else                  run_n = '0;
            unique case (state_q)
                FS_UNLOCKED: if (cls == ERR_SMALL && run_q >= LAST_L) state_n = FS_LOCKED;
                FS_LOCKED:   if (cls == ERR_LARGE) state_n = FS_UNLOCKED;
                default:     state_n = FS_UNLOCKED;
            endcase
        end
    end

    // output process
    always_comb lock_q = (state_q == FS_LOCKED);

endmodule

// File: rtl/ld_status_out.sv
module ld_status_out
    import ld_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_dn,
    input  logic       cp_active,
    input  logic       meas_valid,
    input  logic       lock_q,
    input  logic       ref_div,
    input  logic       fb_div,
    input  logic [1:0] mode_sel,
    output logic       locked,
    output logic       status_out
);

    logic cp_seen_q;
    logic quiet_q;
    logic quiet;

    // analog-style flag, updated at each comparison boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cp_seen_q <= 1'b0;
            quiet_q   <= 1'b0;
        end else if (pwr_dn) begin
            cp_seen_q <= 1'b0;
            quiet_q   <= 1'b0;
        end else if (meas_valid) begin
            quiet_q   <= ~(cp_seen_q | cp_active);
            cp_seen_q <= 1'b0;
        end else begin
            cp_seen_q <= cp_seen_q | cp_active;
        end
    end

    assign locked = lock_q  & ~pwr_dn;
    assign quiet  = quiet_q & ~pwr_dn;

    always_comb begin
        unique case (osel_t'(mode_sel))
            OSEL_FILTERED: status_out = locked;
            OSEL_ANALOG:   status_out = quiet;
            OSEL_REF:      status_out = ref_div;
            OSEL_FB:       status_out = fb_div;
            default:       status_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
    import ld_pkg::*;
#(
    parameter int LOW_TICKS     = 6,
    parameter int HIGH_TICKS    = 12,
    parameter int GOOD_RUN      = 5,
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_div,
    input  logic       fb_div,
    input  logic       pwr_dn,
    input  logic       cp_active,
    input  logic [1:0] mode_sel,
    output logic       locked,
    output logic       status_out
);

    localparam int ERR_W = $clog2(TIMEOUT_TICKS + 1);

    logic             meas_valid;
    logic [ERR_W-1:0] meas_err;
    logic             meas_timeout;
    logic             lock_q;

    ld_edge_meas #(
        .TIMEOUT_TICKS(TIMEOUT_TICKS),
        .ERR_W        (ERR_W)
    ) i_meas (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_div     (ref_div),
        .fb_div      (fb_div),
        .meas_valid  (meas_valid),
        .meas_err    (meas_err),
        .meas_timeout(meas_timeout)
    );

    ld_lock_filter #(
        .LOW_TICKS (LOW_TICKS),
        .HIGH_TICKS(HIGH_TICKS),
        .GOOD_RUN  (GOOD_RUN),
        .ERR_W     (ERR_W)
    ) i_filt (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_dn      (pwr_dn),
        .meas_valid  (meas_valid),
        .meas_err    (meas_err),
        .meas_timeout(meas_timeout),
        .lock_q      (lock_q)
    );

    ld_status_out i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_dn    (pwr_dn),
        .cp_active (cp_active),
        .meas_valid(meas_valid),
        .lock_q    (lock_q),
        .ref_div   (ref_div),
        .fb_div    (fb_div),
        .mode_sel  (mode_sel),
        .locked    (locked),
        .status_out(status_out)
    );

endmodule

// File: rtl/pll_lock_detect_checker.sv
module pll_lock_detect_checker #(
    parameter int LOW_TICKS     = 6,
    parameter int HIGH_TICKS    = 12,
    parameter int TIMEOUT_TICKS = 64,
    parameter int ERR_W         = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_dn,
    input logic             cp_active,
    input logic [1:0]       mode_sel,
    input logic             locked,
    input logic             status_out,
    input logic             meas_valid,
    input logic [ERR_W-1:0] meas_err,
    input logic             meas_timeout
);

    logic big_err, small_err, mid_err;
    assign big_err   = meas_valid && (meas_timeout || meas_err > ERR_W'(HIGH_TICKS));
    assign small_err = meas_valid && !meas_timeout && meas_err < ERR_W'(LOW_TICKS);
    assign mid_err   = meas_valid && !meas_timeout && !big_err && !small_err;

    p_lock_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(small_err));

    p_big_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (big_err && !pwr_dn) |=> !locked);

    p_mid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_err && !pwr_dn) |=> (pwr_dn || locked == $past(locked)));

    p_analog_cp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && cp_active && !pwr_dn && mode_sel == 2'd1) |=> (mode_sel != 2'd1 || !status_out));

    p_err_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && !meas_timeout) |-> (meas_err <= ERR_W'(TIMEOUT_TICKS)));

    p_pd_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_dn) |-> !locked);

endmodule

bind pll_lock_detect pll_lock_detect_checker #(
    .LOW_TICKS    (LOW_TICKS),
    .HIGH_TICKS   (HIGH_TICKS),
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .ERR_W        (ERR_W)
) i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_dn      (pwr_dn),
    .cp_active   (cp_active),
    .mode_sel    (mode_sel),
    .locked      (locked),
    .status_out  (status_out),
    .meas_valid  (meas_valid),
    .meas_err    (meas_err),
    .meas_timeout(meas_timeout)
);

// File: tb/test_pll_lock_detect.sv
module test_pll_lock_detect;

    localparam int CLK_PERIOD = 10;
    localparam int LOW  = 6;
    localparam int HIGH = 12;
    localparam int RUN  = 5;
    localparam int TMO  = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_div = 1'b0;
    logic       fb_div = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       cp_active = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       locked, status_out;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_lock_detect #(
        .LOW_TICKS(LOW), .HIGH_TICKS(HIGH), .GOOD_RUN(RUN), .TIMEOUT_TICKS(TMO)
    ) i_pll_lock_detect (
        .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_div(fb_div),
        .pwr_dn(pwr_dn), .cp_active(cp_active), .mode_sel(mode_sel),
        .locked(locked), .status_out(status_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model: timestamps of leading edges
    int  cyc = 0;
    int  lead = 0;       // 0 none, 1 reference leads, 2 feedback leads
    int  lead_t = 0;
    bit  pv = 0, pt = 0;
    int  pe = 0;
    int  run = 0;
    bit  m_lock = 0, m_quiet = 0, m_seen = 0;
    bit  pr = 0, pf = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; lead = 0; pv = 0; pt = 0; pe = 0; run = 0;
            m_lock = 0; m_quiet = 0; m_seen = 0; pr = 0; pf = 0;
        end else begin
            bit rr, fr, nv, nt;
            int ne;
            if (pwr_dn) begin
                m_lock = 0; run = 0;
            end else if (pv) begin
                if (pt || pe > HIGH) begin run = 0; m_lock = 0; end
                else if (pe < LOW) begin
                    run++;
                    if (run >= RUN) begin run = RUN; m_lock = 1; end
                end else run = 0;
            end
            if (pwr_dn) begin m_quiet = 0; m_seen = 0; end
            else if (pv) begin m_quiet = !(m_seen || cp_active); m_seen = 0; end
            else m_seen = m_seen || cp_active;

            rr = ref_div && !pr;
            fr = fb_div && !pf;
            nv = 0; nt = 0; ne = 0;
            if (lead == 0) begin
                if (rr && fr) nv = 1;
                else if (rr) begin lead = 1; lead_t = cyc; end
                else if (fr) begin lead = 2; lead_t = cyc; end
            end else begin
                bit other, same;
                other = (lead == 1) ? fr : rr;
                same  = (lead == 1) ? rr : fr;
                if (other) begin nv = 1; ne = cyc - lead_t; lead = 0; end
                else if (same) begin nv = 1; nt = 1; lead_t = cyc; end
                else if (cyc - lead_t == TMO) begin nv = 1; nt = 1; lead = 0; end
            end
            pv = nv; pt = nt; pe = ne;
            pr = ref_div; pf = fb_div;
            cyc++;
        end
    end

    // compare every clock, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) begin
            bit e_lock, e_stat;
            e_lock = m_lock && !pwr_dn;
            case (mode_sel)
                2'd0: e_stat = e_lock;
                2'd1: e_stat = m_quiet && !pwr_dn;
                2'd2: e_stat = ref_div;
                default: e_stat = fb_div;
            endcase
            chk(locked == e_lock, "R3 model locked", locked, e_lock);
            chk(status_out == e_stat, (mode_sel == 2'd1) ? "R6 model status" : "R7 model status",
                status_out, e_stat);
        end
    end

    task automatic pair(input bit ref_first, input int gap);
        @(negedge clk);
        if (gap == 0) begin ref_div = 1; fb_div = 1; end
        else if (ref_first) ref_div = 1;
        else fb_div = 1;
        for (int i = 0; i < gap; i++) @(negedge clk);
        ref_div = 1; fb_div = 1;
        repeat (3) @(negedge clk);
        ref_div = 0; fb_div = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic lone_ref();
        @(negedge clk); ref_div = 1;
        repeat (TMO + 4) @(negedge clk);
        ref_div = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic double_ref();
        @(negedge clk); ref_div = 1;
        repeat (2) @(negedge clk); ref_div = 0;
        repeat (2) @(negedge clk); ref_div = 1;
        repeat (2) @(negedge clk); fb_div = 1;
        repeat (3) @(negedge clk); ref_div = 0; fb_div = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(locked == 0, "R1 reset locked", locked, 0);
        chk(status_out == 0, "R1 reset status", status_out, 0);

        // R3: four small errors do not lock, the fifth does
        repeat (4) pair(1, 2);
        chk(locked == 0, "R3 four good", locked, 0);
        pair(1, 2);
        chk(locked == 1, "R3 five good", locked, 1);

        // R5: mid-band error keeps lock
        pair(0, 8);
        chk(locked == 1, "R5 mid keeps lock", locked, 1);
        pair(1, HIGH);
        chk(locked == 1, "R5 boundary HIGH is mid", locked, 1);
        // R4: just above HIGH drops lock
        pair(1, HIGH + 1);
        chk(locked == 0, "R4 large drops", locked, 0);

        // R2: feedback leading, error LOW-1 is small
        repeat (5) pair(0, LOW - 1);
        chk(locked == 1, "R2 fb-lead small errors", locked, 1);
        pair(1, HIGH + 4);
        chk(locked == 0, "R4 drop again", locked, 0);

        // R5: mid error (exactly LOW) restarts the run
        repeat (3) pair(1, 0);
        pair(1, LOW);
        repeat (4) pair(0, 1);
        chk(locked == 0, "R5 run restarted", locked, 0);
        pair(1, 0);
        chk(locked == 1, "R2 simultaneous edges small", locked, 1);

        // R8: timeout and repeated leading edge
        lone_ref();
        chk(locked == 0, "R8 timeout drops", locked, 0);
        repeat (5) pair(1, 3);
        chk(locked == 1, "R3 relock", locked, 1);
        double_ref();
        chk(locked == 0, "R8 repeated lead edge", locked, 0);

        // R9: power-down
        repeat (5) pair(1, 1);
        chk(locked == 1, "R3 relock before pd", locked, 1);
        @(negedge clk); pwr_dn = 1; #1;
        chk(locked == 0, "R9 pd forces low", locked, 0);
        chk(status_out == 0, "R9 pd status low", status_out, 0);
        pair(1, 1);
        @(negedge clk); pwr_dn = 0;
        @(negedge clk);
        chk(locked == 0, "R9 state cleared", locked, 0);
        repeat (4) pair(1, 1);
        chk(locked == 0, "R9 run cleared", locked, 0);

        // R6: analog-style flag
        mode_sel = 2'd1;
        pair(1, 1);
        chk(status_out == 1, "R6 quiet pump", status_out, 1);
        @(negedge clk); cp_active = 1;
        @(negedge clk); cp_active = 0;
        pair(1, 1);
        chk(status_out == 0, "R6 pump active", status_out, 0);
        pair(0, 2);
        chk(status_out == 1, "R6 quiet again", status_out, 1);
        @(negedge clk); pwr_dn = 1; #1;
        chk(status_out == 0, "R9 analog forced low", status_out, 0);
        @(negedge clk); pwr_dn = 0;

        // R7: pass-through selections
        @(negedge clk); mode_sel = 2'd2; ref_div = 1; #1;
        chk(status_out == 1, "R7 ref high", status_out, 1);
        ref_div = 0; #1;
        chk(status_out == 0, "R7 ref low", status_out, 0);
        mode_sel = 2'd3; fb_div = 1; #1;
        chk(status_out == 1, "R7 fb high", status_out, 1);
        fb_div = 0; #1;
        chk(status_out == 0, "R7 fb low", status_out, 0);
        mode_sel = 2'd0; #1;
        chk(status_out == locked, "R7 filtered select", status_out, locked);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule